// File: doc/BRIEF.md
# Memory-Backed Deep FIFO Spill Controller

This block joins two small FIFOs into one very deep FIFO by parking surplus data in external memory through an AXI4 master. An upstream FIFO is filled by the data source. A downstream FIFO is emptied by the sink. Both FIFOs report their occupancy to this block in its own clock domain. While traffic flows freely, the block passes words straight across, one per clock, and the two FIFOs behave as a single FIFO of twice the depth.

When the upstream FIFO backs up past a programmable threshold, the block switches to spill mode. Words from the upstream FIFO are then written as fixed-length bursts into a ring of burst-sized slots in memory. Stored bursts are read back into the downstream FIFO whenever it has room for a whole burst. Two credit registers track how many words have already been promised in each direction. This lets several bursts be queued ahead while write data and read acceptance are never paused once a burst has been requested. When memory holds nothing and the upstream FIFO has dropped below the threshold, the block falls back to straight-through mode.

Top module: `vfifo_spill_ctrl`

## Requirements
- R1: Out of reset, `spill_mode`, `awvalid`, `arvalid`, `wvalid` and `rready` are all low.
- R2: While `spill_mode` is low, in any cycle where the upstream FIFO is not empty and the downstream FIFO is not full, `up_pop` and `dn_push` are both high and `dn_wdata` equals `up_rdata`.
- R3: If `spill_mode` is low and `up_count >= threshold`, then `spill_mode` is high after the next clock edge.
- R4: `spill_mode` falls only after a cycle in which all of these held: `up_count < threshold`, no burst is allocated in memory, and no write burst request was issued. Once all traffic has drained, the block is back in straight-through mode.
- R5: The number of allocated bursts never exceeds 2^LOG2_BURSTS. An allocated burst is one whose write request has been issued and whose read-back has not yet returned its RLAST beat. When the sink stalls long enough, this limit is reached and the upstream side is back-pressured.
- R6: The n-th write request (counted from 0) carries the address ADDR_BASE + (n mod 2^LOG2_BURSTS) * BURST_LEN * (DATA_W/8). It also carries `awlen` = BURST_LEN-1, `awsize` = log2(DATA_W/8) and `awburst` = 2'b01 (incrementing). `awvalid` and `awaddr` hold until `awready`.
- R7: The n-th read request uses the same address sequence and attribute encodings as writes. `arvalid` and `araddr` hold until `arready`.
- R8: `wvalid` is high exactly while fewer W beats have been transferred than BURST_LEN times the number of write requests issued. `wlast` marks every BURST_LEN-th beat. `wdata` is the upstream head word, and each W beat pops it. The upstream FIFO is never popped while empty.
- R9: `rready` is high exactly while some issued read burst has not yet delivered its RLAST beat. Each R beat is pushed into the downstream FIFO, and that FIFO is never pushed while full.
- R10: The number of read requests issued never exceeds the number of write responses received.
- R11: The words leaving the downstream FIFO are exactly the words entering the upstream FIFO, in the same order, with none lost or duplicated, across every change of mode.
- R12: The values on `bresp` and `rresp` have no effect. Error codes on them leave the data stream of R11 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the near sides of both FIFOs |
| rst_n | input | 1 | Active-low synchronous reset |
| threshold | input | CNT_W | Upstream occupancy that triggers spill mode |
| up_count | input | CNT_W | Upstream FIFO occupancy |
| up_empty | input | 1 | Upstream FIFO empty |
| up_rdata | input | DATA_W | Upstream FIFO head word (first-word fall-through) |
| up_pop | output | 1 | Pop the upstream FIFO head |
| dn_count | input | CNT_W | Downstream FIFO occupancy |
| dn_full | input | 1 | Downstream FIFO full |
| dn_wdata | output | DATA_W | Word to write into the downstream FIFO |
| dn_push | output | 1 | Push into the downstream FIFO |
| spill_mode | output | 1 | High while data is routed through memory |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write burst address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DATA_W | Write data |
| wlast | output | 1 | Last beat of a write burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready (always high) |
| bresp | input | 2 | Write response code (ignored) |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | ADDR_W | Read burst address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response code (ignored) |
| rlast | input | 1 | Last beat of a read burst |

## Verification
The straight-through move of R2 is combinational, so the bench checks it in the same cycle, one nanosecond after it drives new FIFO state on the falling edge. The mode change of R3 and R4 appears one edge after the qualifying cycle, so the bench compares the current mode with the conditions it recorded one cycle earlier. A burst request shows up as a rising `awvalid` or `arvalid` one edge after the issuing cycle. In that same cycle `wvalid` or `rready` already reflects the new promise, and the bench's own beat and burst ledgers are updated on that edge before `wvalid` and `rready` are compared. The end-to-end order of R11 and the resting mode of R4 are checked only after the last word has left and twenty further idle cycles have passed.

// File: rtl/vfifo_pkg.sv
`timescale 1ns/1ps
package vfifo_pkg;

  localparam logic [1:0] AXI_BURST_INCR = 2'b01;

  // beat size code: log2 of the byte count per beat
  function automatic logic [2:0] size_code(input int unsigned bytes);
    return 3'($clog2(bytes));
  endfunction

  // address of a ring slot
  function automatic logic [63:0] ring_slot_addr(input logic [63:0] base,
                                                 input logic [31:0] slot,
                                                 input logic [31:0] burst_bytes);
    return base + 64'(slot) * 64'(burst_bytes);
  endfunction

  // credit update: add a step, subtract a step (two's complement, width-free)
  function automatic logic [31:0] credit_next(input logic [31:0] cur,
                                              input logic [31:0] add,
                                              input logic [31:0] sub);
    return cur + add - sub;
  endfunction

endpackage

// File: rtl/vfifo_mode_ctrl.sv
`timescale 1ns/1ps
module vfifo_mode_ctrl #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] up_count,
  input  logic [CNT_W-1:0] threshold,
  input  logic             alloc_zero,
  input  logic             wr_issue,
  output logic             spill_mode
);

  logic over_thr;
  logic enter_spill;
  logic leave_spill;

  assign over_thr    = (up_count >= threshold);
  assign enter_spill = !spill_mode && over_thr;
  assign leave_spill = spill_mode && !over_thr && alloc_zero && !wr_issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spill_mode <= 1'b0;
    end else if (enter_spill) begin
      spill_mode <= 1'b1;
    end else if (leave_spill) begin
      spill_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/vfifo_burst_ledger.sv
`timescale 1ns/1ps
module vfifo_burst_ledger #(
  parameter int LOG2_BURSTS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_issue,
  input  logic                 b_done,
  input  logic                 rd_issue,
  input  logic                 r_done,
  output logic                 alloc_full,
  output logic                 alloc_zero,
  output logic                 stored_nz,
  output logic [LOG2_BURSTS:0] alloc_cnt
);

  localparam int LW = LOG2_BURSTS + 1;
  localparam logic [LW-1:0] SLOTS = LW'(1 << LOG2_BURSTS);

  logic [LW-1:0] alloc_q;
  logic [LW-1:0] stored_q;

  function automatic logic [LW-1:0] step(input logic [LW-1:0] cur,
                                         input logic up, input logic dn);
    return LW'(vfifo_pkg::credit_next(32'(cur), 32'(up), 32'(dn)));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_q  <= '0;
      stored_q <= '0;
    end else begin
      alloc_q  <= step(alloc_q, wr_issue, r_done);
      stored_q <= step(stored_q, b_done, rd_issue);
    end
  end

  assign alloc_full = (alloc_q == SLOTS);
  assign alloc_zero = (alloc_q == '0);
  assign stored_nz  = (stored_q != '0);
  assign alloc_cnt  = alloc_q;

endmodule

// File: rtl/vfifo_wr_engine.sv
`timescale 1ns/1ps
module vfifo_wr_engine #(
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 32,
  parameter int              CNT_W       = 6,
  parameter int              BURST_LEN   = 8,
  parameter int              LOG2_BURSTS = 3,
  parameter logic [ADDR_W-1:0] ADDR_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_mode,
  input  logic [CNT_W-1:0]  up_count,
  input  logic              alloc_full,
  input  logic [DATA_W-1:0] up_rdata,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready,
  output logic              wr_issue,
  output logic              w_beat,
  output logic              b_done
);

  localparam int CRW         = CNT_W + 2;
  localparam int BPW         = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int BURST_BYTES = BURST_LEN * (DATA_W / 8);
  localparam logic [CRW-1:0] BL_C     = CRW'(BURST_LEN);
  localparam logic [CRW-1:0] MIN_INIT = CRW'(BURST_LEN + 8);
  localparam logic [BPW-1:0] POS_LAST = BPW'(BURST_LEN - 1);

  logic [CRW-1:0]         min_up_q;
  logic [CRW-1:0]         beats_left_q;
  logic [BPW-1:0]         beat_pos_q;
  logic [LOG2_BURSTS-1:0] slot_q;
  logic [ADDR_W-1:0]      slot_addr;
  logic                   enough_up;

  function automatic logic [CRW-1:0] adj(input logic [CRW-1:0] cur,
                                         input logic [CRW-1:0] add,
                                         input logic [CRW-1:0] sub);
    return CRW'(vfifo_pkg::credit_next(32'(cur), 32'(add), 32'(sub)));
  endfunction

  assign slot_addr = ADDR_W'(vfifo_pkg::ring_slot_addr(64'(ADDR_BASE), 32'(slot_q),
                                                       32'(BURST_BYTES)));
  assign enough_up = ({2'b00, up_count} >= min_up_q);
  assign wr_issue  = !awvalid && spill_mode && enough_up && !alloc_full;

  assign wvalid  = (beats_left_q != '0);
  assign wdata   = up_rdata;
  assign wlast   = (beat_pos_q == POS_LAST);
  assign w_beat  = wvalid && wready;
  assign bready  = 1'b1;
  assign b_done  = bvalid;
  assign awlen   = 8'(BURST_LEN - 1);
  assign awsize  = vfifo_pkg::size_code(DATA_W / 8);
  assign awburst = vfifo_pkg::AXI_BURST_INCR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      awvalid      <= 1'b0;
      awaddr       <= '0;
      slot_q       <= '0;
      min_up_q     <= MIN_INIT;
      beats_left_q <= '0;
      beat_pos_q   <= '0;
    end else begin
      if (wr_issue) begin
        awvalid <= 1'b1;
        awaddr  <= slot_addr;
        slot_q  <= slot_q + 1'b1;
      end else if (awvalid && awready) begin
        awvalid <= 1'b0;
      end
      min_up_q     <= adj(min_up_q, wr_issue ? BL_C : '0, CRW'(w_beat));
      beats_left_q <= adj(beats_left_q, wr_issue ? BL_C : '0, CRW'(w_beat));
      if (w_beat) begin
        beat_pos_q <= wlast ? '0 : beat_pos_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vfifo_rd_engine.sv
`timescale 1ns/1ps
module vfifo_rd_engine #(
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 32,
  parameter int              CNT_W       = 6,
  parameter int              DN_DEPTH    = 63,
  parameter int              BURST_LEN   = 8,
  parameter int              LOG2_BURSTS = 3,
  parameter logic [ADDR_W-1:0] ADDR_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_mode,
  input  logic [CNT_W-1:0]  dn_count,
  input  logic              stored_nz,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  input  logic              rvalid,
  output logic              rready,
  input  logic              rlast,
  output logic              rd_issue,
  output logic              r_beat,
  output logic              r_done
);

  localparam int CRW         = CNT_W + 2;
  localparam int BURST_BYTES = BURST_LEN * (DATA_W / 8);
  localparam logic [CRW-1:0] BL_C     = CRW'(BURST_LEN);
  localparam logic [CRW-1:0] MAX_INIT = CRW'(DN_DEPTH - BURST_LEN - 8);

  logic [CRW-1:0]         max_dn_q;
  logic [CRW-1:0]         bursts_out_q;
  logic [LOG2_BURSTS-1:0] slot_q;
  logic [ADDR_W-1:0]      slot_addr;
  logic                   credit_neg;
  logic                   room_dn;

  function automatic logic [CRW-1:0] adj(input logic [CRW-1:0] cur,
                                         input logic [CRW-1:0] add,
                                         input logic [CRW-1:0] sub);
    return CRW'(vfifo_pkg::credit_next(32'(cur), 32'(add), 32'(sub)));
  endfunction

  assign slot_addr  = ADDR_W'(vfifo_pkg::ring_slot_addr(64'(ADDR_BASE), 32'(slot_q),
                                                        32'(BURST_BYTES)));
  assign credit_neg = max_dn_q[CRW-1];
  assign room_dn    = ({2'b00, dn_count} <= max_dn_q);
  assign rd_issue   = !arvalid && spill_mode && stored_nz && !credit_neg && room_dn;

  assign rready  = (bursts_out_q != '0);
  assign r_beat  = rvalid && rready;
  assign r_done  = r_beat && rlast;
  assign arlen   = 8'(BURST_LEN - 1);
  assign arsize  = vfifo_pkg::size_code(DATA_W / 8);
  assign arburst = vfifo_pkg::AXI_BURST_INCR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arvalid      <= 1'b0;
      araddr       <= '0;
      slot_q       <= '0;
      max_dn_q     <= MAX_INIT;
      bursts_out_q <= '0;
    end else begin
      if (rd_issue) begin
        arvalid <= 1'b1;
        araddr  <= slot_addr;
        slot_q  <= slot_q + 1'b1;
      end else if (arvalid && arready) begin
        arvalid <= 1'b0;
      end
      max_dn_q     <= adj(max_dn_q, CRW'(r_beat), rd_issue ? BL_C : '0);
      bursts_out_q <= adj(bursts_out_q, CRW'(rd_issue), CRW'(r_done));
    end
  end

endmodule

// File: rtl/vfifo_spill_ctrl.sv
`timescale 1ns/1ps
module vfifo_spill_ctrl #(
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 32,
  parameter int              CNT_W       = 6,
  parameter int              DN_DEPTH    = 63,
  parameter int              BURST_LEN   = 8,
  parameter int              LOG2_BURSTS = 3,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  threshold,
  input  logic [CNT_W-1:0]  up_count,
  input  logic              up_empty,
  input  logic [DATA_W-1:0] up_rdata,
  output logic              up_pop,
  input  logic [CNT_W-1:0]  dn_count,
  input  logic              dn_full,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_push,
  output logic              spill_mode,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast
);

  logic                 wr_issue;
  logic                 rd_issue;
  logic                 w_beat;
  logic                 r_beat;
  logic                 b_done;
  logic                 r_done;
  logic                 alloc_full;
  logic                 alloc_zero;
  logic                 stored_nz;
  logic [LOG2_BURSTS:0] alloc_cnt;
  logic                 pass_move;
  logic                 resp_unused;

  // response codes carry no meaning for this block
  assign resp_unused = ^{bresp, rresp};

  assign pass_move = !spill_mode && !up_empty && !dn_full;
  assign up_pop    = spill_mode ? w_beat : pass_move;
  assign dn_push   = spill_mode ? r_beat : pass_move;
  assign dn_wdata  = spill_mode ? rdata  : up_rdata;

  vfifo_mode_ctrl #(.CNT_W(CNT_W)) mode_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_count   (up_count),
    .threshold  (threshold),
    .alloc_zero (alloc_zero),
    .wr_issue   (wr_issue),
    .spill_mode (spill_mode)
  );

  vfifo_burst_ledger #(.LOG2_BURSTS(LOG2_BURSTS)) ledger_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_issue   (wr_issue),
    .b_done     (b_done),
    .rd_issue   (rd_issue),
    .r_done     (r_done),
    .alloc_full (alloc_full),
    .alloc_zero (alloc_zero),
    .stored_nz  (stored_nz),
    .alloc_cnt  (alloc_cnt)
  );

  vfifo_wr_engine #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN),
    .LOG2_BURSTS(LOG2_BURSTS), .ADDR_BASE(ADDR_BASE)
  ) wr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .spill_mode (spill_mode),
    .up_count   (up_count),
    .alloc_full (alloc_full),
    .up_rdata   (up_rdata),
    .awvalid    (awvalid),
    .awready    (awready),
    .awaddr     (awaddr),
    .awlen      (awlen),
    .awsize     (awsize),
    .awburst    (awburst),
    .wvalid     (wvalid),
    .wready     (wready),
    .wdata      (wdata),
    .wlast      (wlast),
    .bvalid     (bvalid),
    .bready     (bready),
    .wr_issue   (wr_issue),
    .w_beat     (w_beat),
    .b_done     (b_done)
  );

  vfifo_rd_engine #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DN_DEPTH(DN_DEPTH),
    .BURST_LEN(BURST_LEN), .LOG2_BURSTS(LOG2_BURSTS), .ADDR_BASE(ADDR_BASE)
  ) rd_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .spill_mode (spill_mode),
    .dn_count   (dn_count),
    .stored_nz  (stored_nz),
    .arvalid    (arvalid),
    .arready    (arready),
    .araddr     (araddr),
    .arlen      (arlen),
    .arsize     (arsize),
    .arburst    (arburst),
    .rvalid     (rvalid),
    .rready     (rready),
    .rlast      (rlast),
    .rd_issue   (rd_issue),
    .r_beat     (r_beat),
    .r_done     (r_done)
  );

endmodule

// File: rtl/vfifo_spill_ctrl_chk.sv
`timescale 1ns/1ps
module vfifo_spill_ctrl_chk #(
  parameter int ADDR_W      = 32,
  parameter int LOG2_BURSTS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 spill_mode,
  input logic                 up_empty,
  input logic                 dn_full,
  input logic                 up_pop,
  input logic                 dn_push,
  input logic                 awvalid,
  input logic                 awready,
  input logic [ADDR_W-1:0]    awaddr,
  input logic                 arvalid,
  input logic                 arready,
  input logic [ADDR_W-1:0]    araddr,
  input logic                 wvalid,
  input logic                 wlast,
  input logic [LOG2_BURSTS:0] alloc_cnt
);

  localparam int SLOTS = 1 << LOG2_BURSTS;

  // R2
  pass_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spill_mode && !up_empty && !dn_full) |-> (up_pop && dn_push));

  // R6
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

  // R7
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr)));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_pop |-> !up_empty);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_push |-> !dn_full);

  // R8
  wlast_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wlast |-> wvalid);

  // R5
  alloc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(alloc_cnt) <= SLOTS);

endmodule

bind vfifo_spill_ctrl vfifo_spill_ctrl_chk #(
  .ADDR_W(ADDR_W), .LOG2_BURSTS(LOG2_BURSTS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .spill_mode (spill_mode),
  .up_empty   (up_empty),
  .dn_full    (dn_full),
  .up_pop     (up_pop),
  .dn_push    (dn_push),
  .awvalid    (awvalid),
  .awready    (awready),
  .awaddr     (awaddr),
  .arvalid    (arvalid),
  .arready    (arready),
  .araddr     (araddr),
  .wvalid     (wvalid),
  .wlast      (wlast),
  .alloc_cnt  (alloc_cnt)
);

// File: tb/vfifo_spill_ctrl_tb_top.sv
`timescale 1ns/1ps
module vfifo_spill_ctrl_tb_top;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 6;
  localparam int DEPTH  = 63;
  localparam int BL     = 8;
  localparam int LOG2B  = 3;
  localparam int SLOTS  = 1 << LOG2B;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int MEMW   = SLOTS * BL;

  // scenario table: words, source %, sink %, threshold, sink stall, spill expected, full expected
  localparam int NSCN = 5;
  localparam int SCN [NSCN][7] = '{
    '{200, 100, 100, 24,    0, 0, 0},
    '{600,  90,  30, 24,    0, 1, 2},
    '{400,  60,  55, 24,    0, 2, 2},
    '{700, 100, 100, 24, 3000, 1, 1},
    '{300, 100,  15, 40,    0, 1, 2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [CNT_W-1:0]  threshold = 6'd24;
  logic [CNT_W-1:0]  up_count = '0, dn_count = '0;
  logic              up_empty = 1'b1, dn_full = 1'b0;
  logic [DATA_W-1:0] up_rdata = '0, dn_wdata, wdata, rdata = '0;
  logic              up_pop, dn_push, spill_mode;
  logic              awvalid, awready = 1'b0, wvalid, wready = 1'b0, wlast;
  logic              bvalid = 1'b0, bready, arvalid, arready = 1'b0;
  logic              rvalid = 1'b0, rready, rlast = 1'b0;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic [7:0]        awlen, arlen;
  logic [2:0]        awsize, arsize;
  logic [1:0]        awburst, arburst, bresp = '0, rresp = '0;

  vfifo_spill_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DN_DEPTH(DEPTH),
    .BURST_LEN(BL), .LOG2_BURSTS(LOG2B), .ADDR_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .threshold(threshold), .up_count(up_count),
    .up_empty(up_empty), .up_rdata(up_rdata), .up_pop(up_pop), .dn_count(dn_count),
    .dn_full(dn_full), .dn_wdata(dn_wdata), .dn_push(dn_push), .spill_mode(spill_mode),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
    .awburst(awburst), .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bresp(bresp), .arvalid(arvalid), .arready(arready),
    .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst), .rvalid(rvalid),
    .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench model state
  logic [DATA_W-1:0] up_mem [64];
  logic [DATA_W-1:0] dn_mem [64];
  logic [DATA_W-1:0] ram [MEMW];
  int up_wr = 0, up_rd = 0, up_n = 0, dn_wr = 0, dn_rd = 0, dn_n = 0;
  int awq [16]; int awq_h = 0, awq_n = 0, wbeat = 0, b_pend = 0;
  int arq [16]; int arq_h = 0, arq_n = 0, rbeat = 0;
  int sent = 0, rcvd = 0, exp_next = 0, sb_err = 0;
  int cur_n = 0, cur_src = 0, cur_snk = 0, stall_left = 0;
  int aw_hs = 0, ar_hs = 0, aw_iss = 0, ar_iss = 0, w_beats = 0, r_lasts = 0, b_cnt = 0;
  int max_alloc = 0, seen_spill = 0, data_base = 0;
  int e_pass = 0, e_entry = 0, e_exit = 0, e_aw = 0, e_ar = 0, e_wv = 0, e_wl = 0;
  int e_under = 0, e_over = 0, e_rr = 0, e_ord = 0, bad_resp = 0;
  bit src_push = 1'b0, snk_pop = 1'b0, mon_on = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  bit p_spill = 1'b0, p_ge = 1'b0, p_awv = 1'b0, p_arv = 1'b0;
  int p_alloc = 0;

  // state updates at the active edge, using pre-edge values
  always @(posedge clk) begin
    if (rst_n) begin
      if (up_pop) begin
        if (up_n == 0) e_under++; else begin up_rd = (up_rd + 1) % 64; up_n--; end
      end
      if (src_push) begin
        up_mem[up_wr] = src_data; up_wr = (up_wr + 1) % 64; up_n++; sent++;
      end
      if (snk_pop && dn_n > 0) begin
        if (dn_mem[dn_rd] !== DATA_W'(exp_next)) sb_err++;
        exp_next++; rcvd++; dn_rd = (dn_rd + 1) % 64; dn_n--;
      end
      if (dn_push) begin
        if (dn_n >= DEPTH) e_over++;
        else begin dn_mem[dn_wr] = dn_wdata; dn_wr = (dn_wr + 1) % 64; dn_n++; end
      end
      if (awvalid && awready) begin
        if (awaddr !== BASE + 32'((aw_hs % SLOTS) * BL * 4) || awlen !== 8'(BL - 1) ||
            awsize !== 3'd2 || awburst !== 2'b01) e_aw++;
        awq[(awq_h + awq_n) % 16] = int'((awaddr - BASE) >> 2); awq_n++; aw_hs++;
      end
      if (wvalid && wready) begin
        if (wlast !== (wbeat == BL - 1)) e_wl++;
        ram[(awq[awq_h] + wbeat) % MEMW] = wdata; w_beats++;
        if (wbeat == BL - 1) begin wbeat = 0; awq_h = (awq_h + 1) % 16; awq_n--; b_pend++; end
        else wbeat++;
      end
      if (bvalid && bready) begin b_pend--; b_cnt++; end
      if (arvalid && arready) begin
        if (araddr !== BASE + 32'((ar_hs % SLOTS) * BL * 4) || arlen !== 8'(BL - 1) ||
            arsize !== 3'd2 || arburst !== 2'b01) e_ar++;
        arq[(arq_h + arq_n) % 16] = int'((araddr - BASE) >> 2); arq_n++; ar_hs++;
      end
      if (rvalid && rready) begin
        if (rlast) begin rbeat = 0; arq_h = (arq_h + 1) % 16; arq_n--; r_lasts++; end
        else rbeat++;
      end
    end
  end

  // drive inputs after the falling edge, then monitor
  always @(negedge clk) begin
    up_count = CNT_W'(up_n); up_empty = (up_n == 0); up_rdata = up_mem[up_rd];
    dn_count = CNT_W'(dn_n); dn_full = (dn_n >= DEPTH);
    src_push = (sent < cur_n) && (up_n < DEPTH) && (($urandom % 100) < cur_src);
    src_data = DATA_W'(data_base + sent);
    if (stall_left > 0) begin snk_pop = 1'b0; stall_left--; end
    else snk_pop = (dn_n > 0) && (($urandom % 100) < cur_snk);
    awready = ($urandom % 100) < 60;
    wready  = (awq_n > 0) && (($urandom % 100) < 80);
    bvalid  = (b_pend > 0) && (($urandom % 100) < 50);
    bresp   = 2'($urandom % 4);
    arready = ($urandom % 100) < 60;
    rvalid  = (arq_n > 0) && (($urandom % 100) < 75);
    rdata   = ram[(arq[arq_h] + rbeat) % MEMW];
    rlast   = (rbeat == BL - 1);
    rresp   = 2'($urandom % 4);
    if (bresp != 0 || rresp != 0) bad_resp++;
    #1;
    if (mon_on) begin
      if (awvalid && !p_awv) aw_iss++;
      if (arvalid && !p_arv) ar_iss++;
      if (aw_iss - r_lasts > max_alloc) max_alloc = aw_iss - r_lasts;
      if (spill_mode) seen_spill = 1;
      // R2 straight-through move
      if (!spill_mode && !up_empty && !dn_full &&
          !(up_pop && dn_push && dn_wdata === up_rdata)) e_pass++;
      // R3 entry one edge after the qualifying cycle
      if ((!p_spill && p_ge) && !spill_mode) e_entry++;
      if (spill_mode && !p_spill && !p_ge) e_entry++;
      // R4 exit conditions
      if (p_spill && !spill_mode && (p_ge || p_alloc != 0 || (awvalid && !p_awv))) e_exit++;
      // R8 / R9 handshake level
      if (wvalid !== (aw_iss * BL - w_beats > 0)) e_wv++;
      if (rready !== (ar_iss - r_lasts > 0)) e_rr++;
      // R10 read only after write response
      if (ar_iss > b_cnt) e_ord++;
      p_spill = spill_mode; p_ge = (up_count >= threshold); p_awv = awvalid; p_arv = arvalid;
      p_alloc = aw_iss - r_lasts;
    end
  end

  task automatic run_scn(input int idx);
    int cyc;
    int sb0;
    sb0 = sb_err;
    sent = 0; rcvd = 0; data_base = idx * 100000; exp_next = data_base;
    max_alloc = 0; seen_spill = 0;
    threshold = CNT_W'(SCN[idx][3]); cur_src = SCN[idx][1]; cur_snk = SCN[idx][2];
    stall_left = SCN[idx][4]; cur_n = SCN[idx][0];
    cyc = 0;
    while (rcvd < cur_n && cyc < 40000) begin @(negedge clk); cyc++; end
    chk(cyc < 40000, "R11", "watchdog: words received before timeout", rcvd, cur_n);
    repeat (20) @(negedge clk);
    #1;
    chk(rcvd == cur_n, "R11", "word count out", rcvd, cur_n);
    chk(sb_err == sb0, "R11/R12", "order mismatches with error responses present", sb_err - sb0, 0);
    chk(spill_mode == 1'b0, "R4", "resting mode after drain", spill_mode, 0);
    if (SCN[idx][5] != 2) chk(seen_spill == SCN[idx][5], "R3", "spill entered", seen_spill, SCN[idx][5]);
    chk(max_alloc <= SLOTS, "R5", "peak allocated bursts bound", max_alloc, SLOTS);
    if (SCN[idx][6] == 1) chk(max_alloc == SLOTS, "R5", "ring filled", max_alloc, SLOTS);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk(spill_mode == 1'b0, "R1", "spill_mode in reset", spill_mode, 0);
    chk(awvalid == 1'b0, "R1", "awvalid in reset", awvalid, 0);
    chk(arvalid == 1'b0, "R1", "arvalid in reset", arvalid, 0);
    chk(wvalid == 1'b0, "R1", "wvalid in reset", wvalid, 0);
    chk(rready == 1'b0, "R1", "rready in reset", rready, 0);
    @(negedge clk); rst_n = 1'b1; mon_on = 1'b1;
    for (int s = 0; s < NSCN; s++) run_scn(s);
    chk(e_pass == 0, "R2", "straight-through violations", e_pass, 0);
    chk(e_entry == 0, "R3", "spill entry violations", e_entry, 0);
    chk(e_exit == 0, "R4", "spill exit violations", e_exit, 0);
    chk(e_aw == 0, "R6", "write address/attribute errors", e_aw, 0);
    chk(e_ar == 0, "R7", "read address/attribute errors", e_ar, 0);
    chk(ar_hs > SLOTS, "R7", "read ring wrapped", ar_hs, SLOTS + 1);
    chk(e_wv == 0, "R8", "wvalid level errors", e_wv, 0);
    chk(e_wl == 0, "R8", "wlast position errors", e_wl, 0);
    chk(e_under == 0, "R8", "upstream pops while empty", e_under, 0);
    chk(e_rr == 0, "R9", "rready level errors", e_rr, 0);
    chk(e_over == 0, "R9", "downstream pushes while full", e_over, 0);
    chk(e_ord == 0, "R10", "reads ahead of write responses", e_ord, 0);
    chk(bad_resp > 0, "R12", "error responses driven", bad_resp, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule